// File: doc/BRIEF.md
# Latched Fault Interlock with Per-Channel Timestamps

This block guards a group of protected subsystems. Each subsystem drives one fault line. The block synchronises every line and applies a per-channel polarity inversion, so that a high conditioned level always means a fault. Each channel has an enable bit; an enabled fault sets a sticky latch. The latch holds until software issues an explicit reset command, and it survives that command if the fault is still present. When a latch first sets, the block stores the value of a free-running 32-bit microsecond counter for that channel. Each interlock output has a routing mask that selects the latched, enabled faults which force it. An interlocked output is driven low, so a line that loses its drive also reads as an interlock.

After power-up the block is disarmed. In that state all outputs are interlocked and no latch can set. The first reset command arms the block, so monitoring cannot start on its own after a power loss. A sticky change flag, also brought out on a pin, tells software that a latch or an enable bit has changed. Software clears the flag by writing a one to it.

The host port is a simple register bus. A write is taken on the clock edge while `regWr` is high. A read is combinational from `regAddr`. The register map is:

| Address | Access | Contents |
|---|---|---|
| 0x00 | read/write | Enable vector, bit n = channel n |
| 0x01 | read/write | Inversion vector, bit n = channel n |
| 0x02 | write | Bit 0 written as 1 issues the reset/arm command; bit 1 written as 1 clears the change flag |
| 0x02 | read | Bit 0 = armed, bit 1 = change flag |
| 0x03 | read only | Latch vector |
| 0x04 | read only | Live conditioned input vector |
| 0x10+k | read/write | Routing mask of output k |
| 0x40+n | read only | Timestamp of channel n |

Top module: `fault_interlock`

## Requirements
- R1: From reset until the first reset command, the block is disarmed. While disarmed, every `intlkOk` bit is 0, no latch sets even when faults are present, and bit 0 of register 0x02 reads 0. Writing 1 to bit 0 of register 0x02 arms the block.
- R2: The block is fail-safe. With inversion off, a high raw input is a fault, so an open line that is pulled high latches on an enabled channel.
- R3: Setting bit n of register 0x01 inverts channel n before fault evaluation, so a low raw level on that channel is then a fault.
- R4: Once armed, a raw fault change shows in the latch and on the outputs 3 clock edges after the input changes. `intlkOk[k]` is 0 exactly when a latched, enabled channel is selected by the routing mask of output k.
- R5: The tick counter advances once every TICK_DIV clocks, counting from the release of reset. When a latch sets, the timestamp register of its channel (0x40+n) holds the tick value that was current just before the setting edge.
- R6: A channel's timestamp does not change while its latch stays set, whatever its input does.
- R7: A latch clears only on the reset command. The reset command clears a latch whose enabled fault is absent and sets that channel's timestamp to 0. A latch whose fault is still present stays set and keeps its timestamp.
- R8: A disabled channel does not latch. Clearing the enable bit of a latched channel removes it from the outputs but keeps its latch and its timestamp.
- R9: The routing mask at 0x10+k selects which latched faults force output k.
- R10: The change flag (bit 1 of register 0x02, and the `chgFlag` pin) sets whenever any latch changes or a write changes the enable vector. It stays set until software writes 1 to bit 1 of register 0x02.
- R11: After reset, the enable vector is all ones, the inversion vector is all zeros and every routing mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| faultRaw | input | NUM_IN | Raw fault lines from the subsystems |
| intlkOk | output | NUM_OUT | Interlock outputs; 1 = permit, 0 = interlocked |
| chgFlag | output | 1 | Sticky change flag |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data (combinational) |

## Verification
A raw input change reaches the latch, the outputs and the change flag on the third rising edge after it. The bench therefore samples, at the falling edge, once just before that edge and once just after it. A register write takes effect on the edge that captures it, and a read is valid in the same cycle, so every read is made at a falling edge after the write task returns. The expected timestamp is worked out from a cycle counter in the bench that counts edges since the release of reset: a fault driven after edge n stores the tick value (n+2)/TICK_DIV. The random rounds wait for the synchronisers to settle before they arm the block and compare the latches.

// File: rtl/fault_interlock_pkg.sv
package fault_interlock_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] ADDR_EN    = 8'h00;
  localparam logic [7:0] ADDR_INV   = 8'h01;
  localparam logic [7:0] ADDR_CTRL  = 8'h02;
  localparam logic [7:0] ADDR_LATCH = 8'h03;
  localparam logic [7:0] ADDR_LIVE  = 8'h04;
  localparam logic [3:0] PAGE_ROUTE = 4'h1;
  localparam logic [1:0] PAGE_TS    = 2'b01;

  typedef struct packed {
    logic              enWr;
    logic              invWr;
    logic              armCmd;
    logic              flagClr;
    logic              routeWr;
    logic [3:0]        routeIdx;
    logic [DATA_W-1:0] data;
  } hostStrobe_t;
endpackage

// File: rtl/fault_interlock_ctrl.sv
module fault_interlock_ctrl
  import fault_interlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWData,
  output hostStrobe_t       strb,
  output logic              armed
);
  always_comb begin
    strb          = '0;
    strb.data     = regWData;
    strb.enWr     = regWr && (regAddr == ADDR_EN);
    strb.invWr    = regWr && (regAddr == ADDR_INV);
    strb.armCmd   = regWr && (regAddr == ADDR_CTRL) && regWData[0];
    strb.flagClr  = regWr && (regAddr == ADDR_CTRL) && regWData[1];
    strb.routeWr  = regWr && (regAddr[7:4] == PAGE_ROUTE);
    strb.routeIdx = regAddr[3:0];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              armed <= 1'b0;
    else if (strb.armCmd) armed <= 1'b1;
  end
endmodule

// File: rtl/fault_interlock_dp.sv
module fault_interlock_dp
  import fault_interlock_pkg::*;
#(
  parameter int NUM_IN   = 28,
  parameter int NUM_OUT  = 4,
  parameter int TICK_DIV = 100,
  parameter int TS_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_IN-1:0]              faultRaw,
  input  hostStrobe_t                    strb,
  input  logic                           armed,
  input  logic [7:0]                     regAddr,
  output logic [DATA_W-1:0]              regRData,
  output logic [NUM_OUT-1:0]             intlkOk,
  output logic                           chgFlag,
  output logic [NUM_IN-1:0]              latchVec,
  output logic [NUM_IN-1:0]              enVec,
  output logic [NUM_IN-1:0][TS_W-1:0]    tsVec
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [NUM_IN-1:0] syncA, syncB, invQ, enQ, latchQ, cond, hit, latchNext, enNext;
  logic [NUM_OUT-1:0][NUM_IN-1:0] routeQ;
  logic [NUM_IN-1:0][TS_W-1:0]    tsQ;
  logic [PRE_W-1:0] preQ;
  logic [TS_W-1:0]  tickQ;
  logic             chgQ;

  // two-flop synchronizer per input
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= faultRaw;
      syncB <= syncA;
    end
  end

  // microsecond tick
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      preQ  <= '0;
      tickQ <= '0;
    end else if (preQ == PRE_LAST) begin
      preQ  <= '0;
      tickQ <= tickQ + 1'b1;
    end else begin
      preQ  <= preQ + 1'b1;
    end
  end

  assign cond      = syncB ^ invQ;
  assign hit       = cond & enQ;
  assign latchNext = strb.armCmd ? hit : (latchQ | (armed ? hit : '0));
  assign enNext    = strb.enWr ? strb.data[NUM_IN-1:0] : enQ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      enQ    <= '1;
      invQ   <= '0;
      latchQ <= '0;
      chgQ   <= 1'b0;
    end else begin
      enQ    <= enNext;
      if (strb.invWr) invQ <= strb.data[NUM_IN-1:0];
      latchQ <= latchNext;
      chgQ   <= (chgQ & ~strb.flagClr) | (latchNext != latchQ) | (enNext != enQ);
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    always_ff @(posedge clk or posedge rst) begin
      if (rst) routeQ[o] <= '1;
      else if (strb.routeWr && strb.routeIdx == 4'(o)) routeQ[o] <= strb.data[NUM_IN-1:0];
    end
    assign intlkOk[o] = armed & ~|(latchQ & enQ & routeQ[o]);
  end

  for (genvar c = 0; c < NUM_IN; c++) begin : g_ts
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                            tsQ[c] <= '0;
      else if (latchNext[c] & ~latchQ[c]) tsQ[c] <= tickQ;
      else if (~latchNext[c])             tsQ[c] <= '0;
    end
  end

  always_comb begin
    regRData = '0;
    case (regAddr)
      ADDR_EN:    regRData = DATA_W'(enQ);
      ADDR_INV:   regRData = DATA_W'(invQ);
      ADDR_CTRL:  regRData = DATA_W'({chgQ, armed});
      ADDR_LATCH: regRData = DATA_W'(latchQ);
      ADDR_LIVE:  regRData = DATA_W'(cond);
      default: begin
        if (regAddr[7:4] == PAGE_ROUTE) begin
          for (int o = 0; o < NUM_OUT; o++)
            if (regAddr[3:0] == 4'(o)) regRData = DATA_W'(routeQ[o]);
        end else if (regAddr[7:6] == PAGE_TS) begin
          for (int c = 0; c < NUM_IN; c++)
            if (regAddr[5:0] == 6'(c)) regRData = DATA_W'(tsQ[c]);
        end
      end
    endcase
  end

  assign chgFlag  = chgQ;
  assign latchVec = latchQ;
  assign enVec    = enQ;
  assign tsVec    = tsQ;
endmodule

// File: rtl/fault_interlock.sv
module fault_interlock
  import fault_interlock_pkg::*;
#(
  parameter int NUM_IN   = 28,
  parameter int NUM_OUT  = 4,
  parameter int TICK_DIV = 100,
  parameter int TS_W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IN-1:0]  faultRaw,
  output logic [NUM_OUT-1:0] intlkOk,
  output logic               chgFlag,
  input  logic               regWr,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWData,
  output logic [31:0]        regRData
);
  hostStrobe_t                 strb;
  logic                        armed;
  logic [NUM_IN-1:0]           latchVec, enVec;
  logic [NUM_IN-1:0][TS_W-1:0] tsVec;

  fault_interlock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .strb(strb), .armed(armed)
  );

  fault_interlock_dp #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TICK_DIV(TICK_DIV), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rst(rst), .faultRaw(faultRaw), .strb(strb), .armed(armed),
    .regAddr(regAddr), .regRData(regRData), .intlkOk(intlkOk), .chgFlag(chgFlag),
    .latchVec(latchVec), .enVec(enVec), .tsVec(tsVec)
  );
endmodule

// File: rtl/fault_interlock_chk.sv
module fault_interlock_chk #(
  parameter int NUM_IN  = 28,
  parameter int NUM_OUT = 4,
  parameter int TS_W    = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        armed,
  input logic                        armCmd,
  input logic [NUM_IN-1:0]           latchQ,
  input logic [NUM_IN-1:0]           enQ,
  input logic [NUM_IN-1:0][TS_W-1:0] tsQ,
  input logic [NUM_OUT-1:0]          intlkOk,
  input logic                        chgFlag
);
  // R1
  disarmed_safe_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (intlkOk == '0 && latchQ == '0));

  // R1
  arm_by_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(armCmd));

  // R4
  clear_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && ((latchQ & enQ) == '0)) |-> (intlkOk == '1));

  // R7
  latch_clear_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(latchQ) & ~latchQ)) |-> $past(armCmd));

  // R6
  ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latchQ == $past(latchQ)) |-> $stable(tsQ));

  // R10
  chg_on_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (latchQ != $past(latchQ)) |-> chgFlag);
endmodule

bind fault_interlock fault_interlock_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rst(rst), .armed(armed), .armCmd(strb.armCmd),
  .latchQ(latchVec), .enQ(enVec), .tsQ(tsVec), .intlkOk(intlkOk), .chgFlag(chgFlag)
);

// File: tb/fault_interlock_bench.sv
module fault_interlock_bench;
  localparam int NUM_IN   = 28;
  localparam int NUM_OUT  = 4;
  localparam int TICK_DIV = 4;
  localparam logic [31:0] MASK = (32'h1 << NUM_IN) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_IN-1:0]  faultRaw = '0;
  logic [NUM_OUT-1:0] intlkOk;
  logic               chgFlag;
  logic               regWr = 1'b0;
  logic [7:0]         regAddr = '0;
  logic [31:0]        regWData = '0;
  logic [31:0]        regRData;

  int nChk = 0, nErr = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] routeM [NUM_OUT];

  fault_interlock #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TICK_DIV(TICK_DIV)) u_fault_interlock (
    .clk(clk), .rst(rst), .faultRaw(faultRaw), .intlkOk(intlkOk), .chgFlag(chgFlag),
    .regWr(regWr), .regAddr(regAddr), .regWData(regWData), .regRData(regRData)
  );

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NUM_OUT-1:0] expOk(input logic [31:0] lat, input logic [31:0] en);
    logic [NUM_OUT-1:0] r;
    for (int o = 0; o < NUM_OUT; o++) r[o] = ~|(lat & en & routeM[o]);
    return r;
  endfunction

  task automatic arm();
    wrReg(8'h02, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ts0, f, g, en, inv;
    int n;
    void'($urandom(32'd2024));
    for (int o = 0; o < NUM_OUT; o++) routeM[o] = MASK;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R1 outputs interlocked after reset", 32'(intlkOk), 32'h0);
    rdReg(8'h00, d); check("R11 enable reset value", d, MASK);
    rdReg(8'h01, d); check("R11 inversion reset value", d, 32'h0);
    rdReg(8'h12, d); check("R11 route reset value", d, MASK);
    rdReg(8'h02, d); check("R1 armed bit clear", d & 32'h1, 32'h0);

    // disarmed: faults do not latch
    faultRaw[5] = 1'b1; waitCyc(6);
    rdReg(8'h03, d); check("R1 no latch while disarmed", d, 32'h0);
    check("R1 outputs low while disarmed", 32'(intlkOk), 32'h0);
    faultRaw = '0; waitCyc(4);
    arm();
    rdReg(8'h02, d); check("R1 armed after command", d & 32'h1, 32'h1);
    check("R4 outputs permit when healthy", 32'(intlkOk), 32'hF);

    // latency and timestamp
    faultRaw[3] = 1'b1; n = cyc;
    waitCyc(2);
    rdReg(8'h03, d); check("R4 no latch before third edge", d, 32'h0);
    check("R4 outputs before third edge", 32'(intlkOk), 32'hF);
    waitCyc(1);
    rdReg(8'h03, d); check("R2 open-high input latches", d, 32'h8);
    check("R4 outputs drop on third edge", 32'(intlkOk), 32'h0);
    rdReg(8'h43, ts0); check("R5 timestamp value", ts0, 32'((n + 2) / TICK_DIV));

    // later activity keeps timestamp
    for (int k = 0; k < 5; k++) begin
      faultRaw[3] = 1'b0; waitCyc(3);
      faultRaw[3] = 1'b1; waitCyc(4);
    end
    rdReg(8'h43, d); check("R6 timestamp unchanged by later edges", d, ts0);

    // reset with fault present, then absent
    arm();
    rdReg(8'h03, d); check("R7 latch survives reset with fault", d, 32'h8);
    rdReg(8'h43, d); check("R7 timestamp kept on surviving latch", d, ts0);
    faultRaw[3] = 1'b0; waitCyc(5);
    rdReg(8'h03, d); check("R7 latch holds after fault goes", d, 32'h8);
    arm();
    rdReg(8'h03, d); check("R7 latch cleared by command", d, 32'h0);
    rdReg(8'h43, d); check("R7 cleared timestamp", d, 32'h0);
    check("R7 outputs permit after clear", 32'(intlkOk), 32'hF);

    // inversion
    wrReg(8'h01, 32'h80); waitCyc(4);
    rdReg(8'h03, d); check("R3 inverted low input is fault", d, 32'h80);
    faultRaw[7] = 1'b1; waitCyc(4); arm();
    rdReg(8'h03, d); check("R3 inverted high input is healthy", d, 32'h0);

    // enables
    wrReg(8'h00, MASK & ~32'h200); faultRaw[9] = 1'b1; waitCyc(5);
    rdReg(8'h03, d); check("R8 disabled channel does not latch", d, 32'h0);
    check("R8 outputs with disabled fault", 32'(intlkOk), 32'hF);
    wrReg(8'h00, MASK); waitCyc(1);
    rdReg(8'h03, d); check("R8 enabled channel latches", d, 32'h200);
    rdReg(8'h49, ts0);
    wrReg(8'h00, MASK & ~32'h200);
    check("R8 disable masks outputs", 32'(intlkOk), 32'hF);
    rdReg(8'h03, d); check("R8 disable keeps latch", d, 32'h200);
    rdReg(8'h49, d); check("R8 disable keeps timestamp", d, ts0);
    wrReg(8'h00, MASK); faultRaw[9] = 1'b0; waitCyc(4); arm();

    // routing
    routeM[0] = 32'h4; routeM[1] = 32'h10; routeM[2] = 32'h0; routeM[3] = 32'h0;
    for (int o = 0; o < NUM_OUT; o++) wrReg(8'h10 + 8'(o), routeM[o]);
    faultRaw[2] = 1'b1; waitCyc(4);
    check("R9 route selects output 0", 32'(intlkOk), 32'hE);
    faultRaw[2] = 1'b0; faultRaw[4] = 1'b1; waitCyc(4);
    check("R9 route selects output 1", 32'(intlkOk), 32'hC);
    faultRaw[4] = 1'b0; waitCyc(4); arm();
    for (int o = 0; o < NUM_OUT; o++) begin
      routeM[o] = MASK; wrReg(8'h10 + 8'(o), MASK);
    end

    // change flag
    wrReg(8'h02, 32'h2);
    rdReg(8'h02, d); check("R10 flag cleared by write one", d & 32'h2, 32'h0);
    wrReg(8'h00, MASK);
    check("R10 same enable value leaves flag", 32'(chgFlag), 32'h0);
    wrReg(8'h00, MASK & ~32'h1);
    check("R10 enable change sets flag", 32'(chgFlag), 32'h1);
    wrReg(8'h02, 32'h2); wrReg(8'h00, MASK); wrReg(8'h02, 32'h2);
    faultRaw[11] = 1'b1; waitCyc(2);
    check("R10 flag clear before latch", 32'(chgFlag), 32'h0);
    waitCyc(1);
    check("R10 latch sets flag", 32'(chgFlag), 32'h1);
    waitCyc(3);
    check("R10 flag sticky", 32'(chgFlag), 32'h1);
    faultRaw[11] = 1'b0; waitCyc(4); arm();

    // random rounds
    for (int it = 0; it < 40; it++) begin
      en  = $urandom() & MASK;
      inv = $urandom() & MASK;
      f   = $urandom() & $urandom() & $urandom() & MASK;
      g   = $urandom() & MASK;
      for (int o = 0; o < NUM_OUT; o++) begin
        routeM[o] = $urandom() & MASK; wrReg(8'h10 + 8'(o), routeM[o]);
      end
      wrReg(8'h00, en); wrReg(8'h01, inv);
      faultRaw = NUM_IN'(f ^ inv); waitCyc(4); arm();
      rdReg(8'h03, d); check("R4 random latch pattern", d, f & en);
      check("R9 random outputs", 32'(intlkOk), 32'(expOk(f, en)));
      faultRaw = NUM_IN'((f & g) ^ inv); waitCyc(4);
      rdReg(8'h03, d); check("R7 random latch sticky", d, f & en);
      arm();
      rdReg(8'h03, d); check("R7 random reset leaves present faults", d, f & g & en);
      check("R3 random outputs after reset", 32'(intlkOk), 32'(expOk(f & g, en)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule